// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Radio-State Pin Sourcing

This block drives and senses a 32-pin general-purpose I/O bus arranged as two 16-pin banks: a receive-side bank on the low half and a transmit-side bank on the high half. Each pin has three control bits: whether it is an output, a value written by software, and a select that chooses its source. When the select is clear, the pin drives the software value. When the select is set, the pin drives a bit taken from one of four radio-state words. The word in use follows the current radio state, which is idle, receiving, transmitting or full duplex.

The radio state comes straight from two status inputs, `tx_active` and `rx_active`. As the radio changes state, the selected pins follow with no software action. A plain register port reaches every control register. Each access carries a bank select, and each write carries a bit mask, so one access can update a subset of one bank's pins without touching the others. Two pair-load addresses program the state words the usual way: the receive value goes into the idle and RX words, and the transmit value goes into the TX and full-duplex words. The port can also read back the levels present on each bank's pins.

Top module: `gpio_atr_ctrl`

## Requirements
- R1: After reset, every pin has `pin_oe`=0 and `pin_out`=0, and every register reads back as zero.
- R2: Bank select 0 addresses the receive bank on pin bits 15:0. Bank select 1 addresses the transmit bank on pin bits 31:16.
- R3: A write to address 0 (direction) changes only the bits set in `reg_wmask`, and each changed bit takes the value in `reg_wdata`. A direction bit of 1 sets `pin_oe` for that pin from the cycle after the write. Only a direction write changes `pin_oe`.
- R4: Address 1 holds the software output value and address 2 holds the source select. Both take masked writes. An output pin whose select bit is 0 drives its software output bit.
- R5: A pin whose direction bit is 0 has `pin_oe`=0 and `pin_out`=0, whatever its source select holds.
- R6: The radio state is built from the status inputs as follows: neither active gives IDLE, `rx_active` alone gives RX, `tx_active` alone gives TX, and both active give FULL.
- R7: An output pin whose select bit is 1 drives its bit of the state word for the current radio state. Addresses 4, 5, 6 and 7 hold the IDLE, RX, TX and FULL words respectively, each written with a mask. A change of `tx_active` or `rx_active` shows on `pin_out` in the same cycle.
- R8: A masked write to address 8 loads the value into both the IDLE and RX words. A masked write to address 9 loads the value into both the TX and FULL words. Both addresses read back as zero.
- R9: A read of address 3 returns the addressed bank's pin levels as sampled at the previous clock edge. Writes to address 3 have no effect. Unmapped addresses read as zero.
- R10: A write to one bank leaves every register of the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_bank | input | 1 | Bank select: 0 receive, 1 transmit |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write value |
| reg_wmask | input | 16 | Write mask; only set bits are updated |
| reg_rdata | output | 16 | Combinational read value for the addressed bank and register |
| tx_active | input | 1 | Radio transmit status |
| rx_active | input | 1 | Radio receive status |
| pin_in | input | 32 | Pin levels sensed from the bus |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin output enables; 0 means tri-stated |

## Verification
The source mux is exercised with mixed direction and select masks on both banks. A pin that is wrongly routed to software shows up as a different value from one that is wrongly routed to a state word. An input pin that leaks its source shows up as a nonzero output under an all-zero direction. All four combinations of the status inputs are applied against four distinct state words, so a swapped decode of TX and RX produces a visible mismatch. Partial masks, including an empty mask, are applied to direction writes, and the other bank is read back after each write. This separates a correct masked merge from a full overwrite and from a write that lands in the wrong bank. The pair-load addresses are checked by reading back all four words.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;
  localparam int ADDR_W = 4;
  localparam int NUM_STATES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX   = 2'd2,
    ST_FULL = 2'd3
  } atr_state_e;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR     = 4'd0,
    A_OUT     = 4'd1,
    A_SEL     = 4'd2,
    A_PINS    = 4'd3,
    A_W_IDLE  = 4'd4,
    A_W_RX    = 4'd5,
    A_W_TX    = 4'd6,
    A_W_FULL  = 4'd7,
    A_PAIR_RX = 4'd8,
    A_PAIR_TX = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/gpio_atr_state.sv
module gpio_atr_state
  import gpio_atr_pkg::*;
(
  input  logic       tx_active,
  input  logic       rx_active,
  output atr_state_e state
);
  always_comb begin
    unique case ({tx_active, rx_active})
      2'b00:   state = ST_IDLE;
      2'b01:   state = ST_RX;
      2'b10:   state = ST_TX;
      default: state = ST_FULL;
    endcase
  end
endmodule

// File: rtl/gpio_atr_bank.sv
module gpio_atr_bank
  import gpio_atr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      wmask,
  input  atr_state_e        state,
  input  logic [W-1:0]      pins_in,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      pins_out,
  output logic [W-1:0]      pins_oe
);
  logic [W-1:0] dir_q, out_q, sel_q, pin_q;
  logic [W-1:0] atr_q [NUM_STATES];
  logic [W-1:0] atr_now;

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_v,
                                         input logic [W-1:0] new_v,
                                         input logic [W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // State-word write decode: direct address or pair-load address
  logic [NUM_STATES-1:0] atr_hit;
  generate
    for (genvar s = 0; s < NUM_STATES; s++) begin : g_hit
      localparam logic [ADDR_W-1:0] DIRECT = ADDR_W'(int'(A_W_IDLE) + s);
      localparam logic [ADDR_W-1:0] PAIR   = (s < 2) ? A_PAIR_RX : A_PAIR_TX;
      assign atr_hit[s] = wr_en && ((addr == DIRECT) || (addr == PAIR));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      sel_q <= '0;
      pin_q <= '0;
      for (int s = 0; s < NUM_STATES; s++) atr_q[s] <= '0;
    end else begin
      pin_q <= pins_in;
      if (wr_en) begin
        case (addr)
          A_DIR:   dir_q <= merge(dir_q, wdata, wmask);
          A_OUT:   out_q <= merge(out_q, wdata, wmask);
          A_SEL:   sel_q <= merge(sel_q, wdata, wmask);
          default: ;
        endcase
      end
      for (int s = 0; s < NUM_STATES; s++)
        if (atr_hit[s]) atr_q[s] <= merge(atr_q[s], wdata, wmask);
    end
  end

  always_comb begin
    case (addr)
      A_DIR:    rdata = dir_q;
      A_OUT:    rdata = out_q;
      A_SEL:    rdata = sel_q;
      A_PINS:   rdata = pin_q;
      A_W_IDLE: rdata = atr_q[0];
      A_W_RX:   rdata = atr_q[1];
      A_W_TX:   rdata = atr_q[2];
      A_W_FULL: rdata = atr_q[3];
      default:  rdata = '0;
    endcase
  end

  assign atr_now = atr_q[state];
  assign pins_oe = dir_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic src;
      assign src         = sel_q[i] ? atr_now[i] : out_q[i];
      assign pins_out[i] = dir_q[i] & src;
    end
  endgenerate
endmodule

// File: rtl/gpio_atr_ctrl.sv
module gpio_atr_ctrl
  import gpio_atr_pkg::*;
#(
  parameter int BANK_W = 16,
  localparam int PIN_W = 2 * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_bank,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  input  logic [BANK_W-1:0] reg_wmask,
  output logic [BANK_W-1:0] reg_rdata,
  input  logic              tx_active,
  input  logic              rx_active,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  atr_state_e  state;
  logic [BANK_W-1:0] bank_rdata [2];

  gpio_atr_state u_state (
    .tx_active (tx_active),
    .rx_active (rx_active),
    .state     (state)
  );

  // Bank 0: receive, low half. Bank 1: transmit, high half.
  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      gpio_atr_bank #(.W(BANK_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr && (reg_bank == 1'(b))),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .wmask    (reg_wmask),
        .state    (state),
        .pins_in  (pin_in[b*BANK_W +: BANK_W]),
        .rdata    (bank_rdata[b]),
        .pins_out (pin_out[b*BANK_W +: BANK_W]),
        .pins_oe  (pin_oe[b*BANK_W +: BANK_W])
      );
    end
  endgenerate

  assign reg_rdata = bank_rdata[reg_bank];
endmodule

// File: rtl/gpio_atr_ctrl_chk.sv
module gpio_atr_ctrl_chk
  import gpio_atr_pkg::*;
#(
  parameter int BANK_W = 16,
  localparam int PIN_W = 2 * BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_bank,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BANK_W-1:0] reg_wdata,
  input logic [BANK_W-1:0] reg_wmask,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe
);
  logic dir_wr;
  assign dir_wr = reg_wr && (reg_addr == A_DIR);

  // R5: a disabled pin never drives high
  p_tristate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R3: enables move only on a direction write
  p_oe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(pin_oe));

  // R3: masked merge into the addressed bank
  p_dir_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=>
      ((($past(reg_bank) ? pin_oe[PIN_W-1:BANK_W] : pin_oe[BANK_W-1:0])) ==
       ((($past(reg_bank) ? $past(pin_oe[PIN_W-1:BANK_W]) : $past(pin_oe[BANK_W-1:0]))
         & ~$past(reg_wmask)) | ($past(reg_wdata) & $past(reg_wmask)))));

  // R10: the other bank's enables stay put
  p_dir_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=>
      (($past(reg_bank) ? pin_oe[BANK_W-1:0] : pin_oe[PIN_W-1:BANK_W]) ==
       ($past(reg_bank) ? $past(pin_oe[BANK_W-1:0]) : $past(pin_oe[PIN_W-1:BANK_W]))));
endmodule

bind gpio_atr_ctrl gpio_atr_ctrl_chk #(.BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_bank  (reg_bank),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_wmask (reg_wmask),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/tb_gpio_atr_ctrl.sv
module tb_gpio_atr_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic        reg_bank = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_wmask = 0;
  logic [15:0] reg_rdata;
  logic        tx_active = 0;
  logic        rx_active = 0;
  logic [31:0] pin_in = 0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_atr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_bank(reg_bank),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask),
    .reg_rdata(reg_rdata), .tx_active(tx_active), .rx_active(rx_active),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic        bank;
    logic [15:0] dir;
    logic [15:0] outv;
    logic [15:0] sel;
    logic [15:0] rxw;
    logic [15:0] txw;
    logic        tx;
    logic        rx;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'hFFFF, 16'hA5A5, 16'h0000, 16'h1234, 16'h5678, 1'b0, 1'b0},
    '{1'b1, 16'hFF00, 16'h0F0F, 16'h00FF, 16'hAAAA, 16'h5555, 1'b0, 1'b1},
    '{1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h1111, 16'h2222, 1'b1, 1'b0},
    '{1'b1, 16'h0FF0, 16'hFFFF, 16'hF0F0, 16'hC3C3, 16'h3C3C, 1'b1, 1'b1},
    '{1'b0, 16'hFFFF, 16'h8001, 16'h0FF0, 16'h7E7E, 16'h0000, 1'b0, 1'b1},
    '{1'b1, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic [3:0] a, input logic [15:0] d, input logic [15:0] m);
    @(negedge clk);
    reg_wr = 1; reg_bank = b; reg_addr = a; reg_wdata = d; reg_wmask = m;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic b, input logic [3:0] a, output logic [15:0] d);
    reg_bank = b; reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [15:0] half(input logic [31:0] v, input logic b);
    return b ? v[31:16] : v[15:0];
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    for (int a = 0; a < 10; a++) begin
      rd(1'b1, 4'(a), d);
      check("R1 readback", {16'h0, d}, 32'h0);
    end

    // Vector table: R2 R4 R7 R6
    foreach (VECS[k]) begin
      vec_t v;
      logic [15:0] atr, exp;
      v = VECS[k];
      wr(v.bank, 4'd0, v.dir, 16'hFFFF);
      wr(v.bank, 4'd1, v.outv, 16'hFFFF);
      wr(v.bank, 4'd2, v.sel, 16'hFFFF);
      wr(v.bank, 4'd8, v.rxw, 16'hFFFF);
      wr(v.bank, 4'd9, v.txw, 16'hFFFF);
      tx_active = v.tx; rx_active = v.rx;
      #1;
      atr = v.tx ? v.txw : v.rxw;
      exp = v.dir & ((v.sel & atr) | (~v.sel & v.outv));
      check("R2/R4/R7 pin_out half", {16'h0, half(pin_out, v.bank)}, {16'h0, exp});
      check("R2/R3 pin_oe half", {16'h0, half(pin_oe, v.bank)}, {16'h0, v.dir});
    end

    // Clear both banks
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 10; a++) wr(1'(b), 4'(a), 16'h0000, 16'hFFFF);
    tx_active = 0; rx_active = 0;

    // R3: masked direction writes; R10: other bank untouched
    wr(1'b0, 4'd0, 16'hFFFF, 16'h00FF);
    check("R3 dir set masked", pin_oe, 32'h0000_00FF);
    wr(1'b0, 4'd0, 16'h0000, 16'h000F);
    check("R3 dir clear masked", pin_oe, 32'h0000_00F0);
    wr(1'b0, 4'd0, 16'hFFFF, 16'h0000);
    check("R3 empty mask", pin_oe, 32'h0000_00F0);
    wr(1'b1, 4'd0, 16'hFFFF, 16'hF000);
    check("R10 dir other bank", pin_oe, 32'hF000_00F0);

    // R4: masked output write, R10 other bank's output register
    wr(1'b1, 4'd1, 16'h1234, 16'h0FF0);
    rd(1'b1, 4'd1, d);
    check("R4 out masked", {16'h0, d}, 32'h0000_0230);
    rd(1'b0, 4'd1, d);
    check("R10 out other bank", {16'h0, d}, 32'h0);

    // R5: input pins stay low even when sourced from a state word
    wr(1'b0, 4'd2, 16'hFFFF, 16'hFFFF);
    wr(1'b0, 4'd8, 16'hFFFF, 16'hFFFF);
    check("R5 tristate", {16'h0, pin_out[15:0]}, 32'h0000_00F0);

    // R6 R7: distinct words per state, all pins of RX bank outputs
    wr(1'b0, 4'd0, 16'hFFFF, 16'hFFFF);
    wr(1'b0, 4'd4, 16'h1001, 16'hFFFF);
    wr(1'b0, 4'd5, 16'h2002, 16'hFFFF);
    wr(1'b0, 4'd6, 16'h4004, 16'hFFFF);
    wr(1'b0, 4'd7, 16'h8008, 16'hFFFF);
    for (int s = 0; s < 4; s++) begin
      logic [15:0] e;
      tx_active = s[1]; rx_active = s[0];
      #1;
      e = (s == 0) ? 16'h1001 : (s == 1) ? 16'h2002 : (s == 2) ? 16'h4004 : 16'h8008;
      check("R6/R7 state word", {16'h0, pin_out[15:0]}, {16'h0, e});
    end

    // R8: pair loads, pair addresses read zero
    wr(1'b1, 4'd8, 16'hBEEF, 16'hFFFF);
    wr(1'b1, 4'd9, 16'hCAFE, 16'hFF00);
    rd(1'b1, 4'd4, d); check("R8 idle word", {16'h0, d}, 32'h0000_BEEF);
    rd(1'b1, 4'd5, d); check("R8 rx word", {16'h0, d}, 32'h0000_BEEF);
    rd(1'b1, 4'd6, d); check("R8 tx word", {16'h0, d}, 32'h0000_CA00);
    rd(1'b1, 4'd7, d); check("R8 full word", {16'h0, d}, 32'h0000_CA00);
    rd(1'b1, 4'd8, d); check("R8 pair read zero", {16'h0, d}, 32'h0);

    // R9: pin readback per bank, write to readback ignored, unmapped zero
    @(negedge clk);
    pin_in = 32'h5A5A_C3C3;
    @(negedge clk);
    rd(1'b0, 4'd3, d); check("R9 rx pins", {16'h0, d}, 32'h0000_C3C3);
    rd(1'b1, 4'd3, d); check("R9 tx pins", {16'h0, d}, 32'h0000_5A5A);
    wr(1'b1, 4'd3, 16'h0000, 16'hFFFF);
    rd(1'b1, 4'd3, d); check("R9 write ignored", {16'h0, d}, 32'h0000_5A5A);
    rd(1'b0, 4'd15, d); check("R9 unmapped", {16'h0, d}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule